// File: doc/BRIEF.md
# Cycle-Aligned Output Enable Sequencer

This block decides, for a group of PWM channels that share one period timebase, when each channel may drive its pin. Every change to what drives takes effect on a period boundary, which the timebase marks with a one-clock start strobe. Three things feed into the decision. A global float request is sampled on each boundary. Each channel has an enable flag that a per-channel command strobe writes. A global active-low clear request is held off until the running period ends. It then wipes the enable flags and asks the duty registers to clear.

The block also times the move of a freshly written duty value into the active register of its channel. A pending value moves on the first boundary after the write, and only when the write carried an enable. After a clear, every channel floats until software writes it again with an enable. While the clear request stays low, the block holds the timebase, keeps the duty registers cleared and blocks command writes.

Top module: `pwm_drive_gate`

## Requirements
- R1: After the power-on reset `rst_n` is released, `drv_en_o` is all zero and `duty_clr_o`, `tb_hold_o` and `wr_block_o` are 0.
- R2: A command strobe on channel i with `cmd_en_i`=1 sets bit i of `drv_en_o`. This happens in the clock after the next `cyc_start_i` edge and not before, provided the float input was low at that boundary.
- R3: A command strobe on channel i with `cmd_en_i`=0 clears bit i of `drv_en_o`. Like an enable, it takes effect only at the next boundary.
- R4: `oc_i` is sampled only on a boundary. If it was 1 there, `drv_en_o` is all zero until the next boundary, whatever `oc_i` does in between. If it was 0, changes of `oc_i` within the period have no effect on the outputs.
- R5: `duty_load_o[i]` is high in the same clock as the `cyc_start_i` of the first boundary after an enabling write to channel i. It goes high once per such write and never without a write.
- R6: A command with `cmd_en_i`=0 produces no `duty_load_o` pulse.
- R7: When `rq_n_i` goes low, the outputs keep their state until the next boundary. In the clock of that boundary `duty_clr_o` is 1. After it, `drv_en_o` is all zero. The request stays latched even if `rq_n_i` returns high before the boundary.
- R8: From the clearing boundary until the clock after `rq_n_i` is high again, `duty_clr_o`, `tb_hold_o` and `wr_block_o` are 1. Command strobes in that interval are ignored, so those channels still float after the next boundary.
- R9: After a clear, every channel floats across later boundaries until it receives a new enabling command.
- R10: Channels are independent: a command to one channel changes only that channel's output and load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| oc_i | input | 1 | Global float request, sampled at each boundary |
| rq_n_i | input | 1 | Clear request, active low, deferred to the period end |
| cyc_start_i | input | 1 | One-clock period start strobe from the timebase |
| cmd_stb_i | input | NCH | Per-channel command strobe |
| cmd_en_i | input | 1 | Enable bit carried by the command |
| drv_en_o | output | NCH | Per-channel pin drive enable (0 = high impedance) |
| duty_load_o | output | NCH | Per-channel transfer of pending duty into the active register |
| duty_clr_o | output | 1 | Clear all duty registers |
| tb_hold_o | output | 1 | Hold the period timebase |
| wr_block_o | output | 1 | Block duty register writes |

## Verification
All sixteen enable masks are stepped through in sequence, with every channel rewritten at each step. Moving from each mask to the next sets some channels and clears others. This separates per-channel independence from a shared enable, and separates enabling from disabling writes in the load pulses. The float input is switched both at boundaries and in the middle of a period, which shows whether it is sampled or passed straight through. The clear request is tried twice. It is held low across a boundary with writes attempted during the hold, and it is also pulsed briefly between boundaries, to check that the request is latched and that the cleared state persists.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
   typedef enum logic [1:0] {
      SQ_RUN  = 2'd0,
      SQ_PEND = 2'd1,
      SQ_HOLD = 2'd2
   } sq_state_t;
endpackage

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq
   import pwm_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic oc_i,
   input  logic rq_n_i,
   input  logic cyc_start_i,
   output logic bnd_o,
   output logic clr_go_o,
   output logic hold_o,
   output logic oc_lat_o
);
   sq_state_t st_q;
   logic      oc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SQ_RUN;
         oc_q <= 1'b1;
      end else begin
         unique case (st_q)
            SQ_RUN:  if (!rq_n_i)     st_q <= SQ_PEND;
            SQ_PEND: if (cyc_start_i) st_q <= SQ_HOLD;
            SQ_HOLD: if (rq_n_i)      st_q <= SQ_RUN;
            default:                  st_q <= SQ_RUN;
         endcase
         if (cyc_start_i && st_q != SQ_HOLD) oc_q <= oc_i;
      end
   end

   always_comb begin
      bnd_o    = cyc_start_i && (st_q != SQ_HOLD);
      clr_go_o = cyc_start_i && (st_q == SQ_PEND);
      hold_o   = (st_q == SQ_HOLD);
      oc_lat_o = oc_q;
   end

   p_hold_after_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_o) |-> $past(cyc_start_i));
   p_hold_left_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_o) |-> $past(rq_n_i));
endmodule

// File: rtl/pwm_gate_chan.sv
module pwm_gate_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   input  logic en_bit_i,
   input  logic blk_i,
   input  logic bnd_i,
   input  logic clr_go_i,
   output logic act_o,
   output logic load_o
);
   logic pend_en_q, act_q, ld_q;
   logic wr_ok;

   assign wr_ok = stb_i && !blk_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_en_q <= 1'b0;
         act_q     <= 1'b0;
         ld_q      <= 1'b0;
      end else if (clr_go_i) begin
         pend_en_q <= 1'b0;
         act_q     <= 1'b0;
         ld_q      <= 1'b0;
      end else begin
         if (wr_ok) pend_en_q <= en_bit_i;
         if (bnd_i) act_q <= pend_en_q;
         if (wr_ok)      ld_q <= en_bit_i;
         else if (bnd_i) ld_q <= 1'b0;
      end
   end

   assign act_o  = act_q;
   assign load_o = bnd_i && ld_q && !clr_go_i;

   p_act_moves_on_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q) |-> $past(bnd_i));
   p_blocked_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && blk_i && !clr_go_i) |=> $stable(pend_en_q));
   p_disable_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !en_bit_i && !clr_go_i) |=> !ld_q);
endmodule

// File: rtl/pwm_drive_gate.sv
module pwm_drive_gate #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           oc_i,
   input  logic           rq_n_i,
   input  logic           cyc_start_i,
   input  logic [NCH-1:0] cmd_stb_i,
   input  logic           cmd_en_i,
   output logic [NCH-1:0] drv_en_o,
   output logic [NCH-1:0] duty_load_o,
   output logic           duty_clr_o,
   output logic           tb_hold_o,
   output logic           wr_block_o
);
   localparam int unsigned NMAX = 16;

   if (NCH < 1 || NCH > NMAX) begin : g_bad_nch
      $error("pwm_drive_gate: NCH out of range");
   end

   logic           bnd, clr_go, hold, oc_lat;
   logic [NCH-1:0] act;

   pwm_gate_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .oc_i        (oc_i),
      .rq_n_i      (rq_n_i),
      .cyc_start_i (cyc_start_i),
      .bnd_o       (bnd),
      .clr_go_o    (clr_go),
      .hold_o      (hold),
      .oc_lat_o    (oc_lat)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      pwm_gate_chan u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .stb_i    (cmd_stb_i[g]),
         .en_bit_i (cmd_en_i),
         .blk_i    (hold),
         .bnd_i    (bnd),
         .clr_go_i (clr_go),
         .act_o    (act[g]),
         .load_o   (duty_load_o[g])
      );
   end

   always_comb begin
      drv_en_o   = act & {NCH{~oc_lat}};
      duty_clr_o = clr_go | hold;
      tb_hold_o  = hold;
      wr_block_o = hold;
   end

   p_float_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tb_hold_o |-> (drv_en_o == '0));
   p_no_load_when_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tb_hold_o |-> (duty_load_o == '0));
   p_load_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_load_o != '0) |-> cyc_start_i);
   p_drive_stable_midcycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cyc_start_i) |-> $stable(drv_en_o));
endmodule

// File: tb/sim_pwm_drive_gate.sv
module sim_pwm_drive_gate;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n, oc, rq_n, cyc, cen;
   logic [N-1:0] stb;
   logic [N-1:0] drv, ld;
   logic         clr, hold, blk;
   int           total = 0, bad = 0;
   bit           done = 1'b0;

   always #5 clk = ~clk;

   pwm_drive_gate #(.NCH(N)) u0 (
      .clk(clk), .rst_n(rst_n), .oc_i(oc), .rq_n_i(rq_n), .cyc_start_i(cyc),
      .cmd_stb_i(stb), .cmd_en_i(cen), .drv_en_o(drv), .duty_load_o(ld),
      .duty_clr_o(clr), .tb_hold_o(hold), .wr_block_o(blk)
   );

   task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
      total++;
      if (a !== e) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, a, e);
      end
   endtask

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic cmd(int ch, logic en);
      @(negedge clk); stb = '0; stb[ch] = 1'b1; cen = en;
      @(negedge clk); stb = '0; #1;
   endtask

   task automatic boundary(output logic [N-1:0] l, output logic c);
      @(negedge clk); cyc = 1'b1; #1; l = ld; c = clr;
      @(negedge clk); cyc = 1'b0; #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] l, prev;
      logic         c;
      rst_n = 1'b0; oc = 1'b0; rq_n = 1'b1; cyc = 1'b0; cen = 1'b0; stb = '0;
      repeat (3) tick();
      rst_n = 1'b1; tick();
      chk("R1 drv", drv, 0);
      chk("R1 clr", clr, 0);
      chk("R1 hold", hold, 0);
      chk("R1 blk", blk, 0);

      // R2 R3 R6 R10: sweep all masks, rewriting every channel
      prev = '0;
      for (int m = 0; m < 16; m++) begin
         for (int ch = 0; ch < N; ch++) cmd(ch, m[ch]);
         chk("R2 R3 before boundary", drv, prev);
         boundary(l, c);
         chk("R5 R6 R10 load", l, m);
         chk("R2 R3 R10 drv", drv, m);
         prev = m[N-1:0];
      end
      boundary(l, c);
      chk("R5 no repeat load", l, 0);

      // R4: float input sampled at boundary
      oc = 1'b1; tick();
      chk("R4 oc mid no effect", drv, 4'hF);
      boundary(l, c);
      chk("R4 float at boundary", drv, 0);
      oc = 1'b0; repeat (3) tick();
      chk("R4 float held mid", drv, 0);
      boundary(l, c);
      chk("R4 drive resumes", drv, 4'hF);

      // R7 R8 R9: clear request held low
      cmd(1, 1'b0); cmd(3, 1'b1);
      boundary(l, c);
      chk("R10 mix", drv, 4'b1101);
      cmd(0, 1'b1);
      rq_n = 1'b0; repeat (3) tick();
      chk("R7 drive kept", drv, 4'b1101);
      chk("R7 no hold yet", hold, 0);
      boundary(l, c);
      chk("R7 clr at boundary", c, 1);
      chk("R7 no load on clear", l, 0);
      chk("R7 float", drv, 0);
      chk("R8 hold", hold, 1);
      chk("R8 clr level", clr, 1);
      chk("R8 blk", blk, 1);
      for (int ch = 0; ch < N; ch++) cmd(ch, 1'b1);
      boundary(l, c);
      chk("R8 held boundary", drv, 0);
      rq_n = 1'b1; tick();
      chk("R8 hold released", hold, 0);
      chk("R8 clr released", clr, 0);
      boundary(l, c);
      chk("R8 blocked writes lost", l, 0);
      chk("R9 float after release", drv, 0);
      boundary(l, c);
      chk("R9 still float", drv, 0);
      cmd(2, 1'b1);
      boundary(l, c);
      chk("R9 load ch2", l, 4'b0100);
      chk("R9 ch2 drives", drv, 4'b0100);

      // R7: short request between boundaries stays latched
      tick(); rq_n = 1'b0; tick(); rq_n = 1'b1; tick();
      chk("R7 latched no effect yet", drv, 4'b0100);
      boundary(l, c);
      chk("R7 latched clr", c, 1);
      chk("R7 latched float", drv, 0);
      tick();
      chk("R8 short hold exits", hold, 0);
      boundary(l, c);
      chk("R9 float after short clear", drv, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule